// File: doc/BRIEF.md
# Radio Warm-Up / Warm-Down Event Sequencer

This block steps a radio front end through its power-up and power-down phases without help from the host. It holds a table of timed events. Each event names one control output, says whether to drive it high or low, and gives the count within the phase at which this happens. A run is launched either by a pulse from an external timer or by a software start pulse. It then plays a warm-up phase, rests in an "on" state, and plays a warm-down phase once a warm-down trigger arrives. The warm-down phase starts at once, or after a programmed number of cycles counted from the trigger.

The table can be split into four fixed regions: receive warm-up, receive warm-down, transmit warm-up and transmit warm-down. A select input picks receive or transmit at launch. The table can instead be used as one combined sequence, with one half for warm-up and one half for warm-down. Three pending flags, each with its own enable and clear, report warm-up done, warm-down done and an error or abort. Every control output can be forced to a software value while the sequence keeps running underneath.

Top module: `rf_evseq`

## Requirements
- R1: After reset, every control output is 0 when no override is active, all three interrupt lines are 0, and the sequencer is idle.
- R2: In idle, a `sw_start` pulse, or a `tmr_tick` while `cfg_tmr_en`=1, launches warm-up on the next edge. A `tmr_tick` while `cfg_tmr_en`=0 has no effect.
- R3: A table word is {count[21:6], output index[5:1], set[0]}, where set=1 drives the output high and 0 drives it low. Within a phase the count starts at 0. The entries of the phase's region are visited in ascending index order. The current entry fires on an edge where the count equals its trigger count. The count holds on each edge where an entry fires, so entries with equal counts fire on consecutive edges; otherwise it advances by one.
- R4: The mode and the receive/transmit select are captured at launch. With `cfg_split`=1, the regions are entries 0-7 (receive warm-up), 8-15 (receive warm-down), 16-23 (transmit warm-up) and 24-31 (transmit warm-down), and `cfg_tx`=1 picks transmit. With `cfg_split`=0, entries 0-15 form the warm-up and 16-31 the warm-down, whatever `cfg_tx` is.
- R5: When the last entry of the warm-up region fires, the sequencer enters the on state and sets pending flag 0 (warm-up done).
- R6: In the on state, `wd_trig` with `wd_dly`=0 starts warm-down on the next edge. With `wd_dly`=D>0, warm-down starts D edges later. `wd_trig` has no effect in any other state.
- R7: When the last entry of the warm-down region fires, the sequencer returns to idle and sets pending flag 1 (warm-down done).
- R8: A start request (as defined in R2) while the sequencer is not idle is ignored, and it sets pending flag 2 (error).
- R9: If the current entry's trigger count is below the current count, the phase aborts to idle with no output change and sets pending flag 2.
- R10: `irq` = pending & `irq_en`. A 1 on `irq_clr` clears that pending bit. A set on the same edge wins over the clear.
- R11: Each `ctl_out` bit equals `ovr_val` while its `ovr_en` bit is 1, and the sequenced value otherwise. Events keep updating the sequenced value while it is overridden.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 5 | Table entry to write |
| tbl_wdata | input | 22 | Entry word {count, index, set} |
| cfg_split | input | 1 | 1 = four separate regions, 0 = combined |
| cfg_tx | input | 1 | 1 = transmit sequence in split mode |
| cfg_tmr_en | input | 1 | Allow timer pulses to launch |
| tmr_tick | input | 1 | External timer pulse |
| sw_start | input | 1 | Software start pulse |
| wd_trig | input | 1 | Warm-down trigger |
| wd_dly | input | 16 | Warm-down delay in cycles, 0 = immediate |
| ovr_en | input | 32 | Per-output override enable |
| ovr_val | input | 32 | Per-output override value |
| irq_en | input | 3 | Interrupt enables {error, wd done, wu done} |
| irq_clr | input | 3 | Pending clear pulses, same bit order |
| ctl_out | output | 32 | Radio control outputs |
| irq | output | 3 | Masked interrupt lines |

## Verification
The assertions check on every cycle that interrupt lines never show a disabled bit and that overridden outputs follow the override value. They also check that idle and on are left only on a start request or a warm-down trigger, that the delay state exits only into warm-down, that a start while busy raises the error flag, and that the done flags rise only alongside the on or idle state. The exact firing cycle of each event, consecutive firing of equal counts, region selection by mode and direction, the extra cycles added by the warm-down delay, and the abort on a descending entry can only be shown by the bench. Its reference model tracks them over whole runs.

// File: rtl/rf_evseq.sv
module rf_evseq #(
  parameter int N_EVT = 32,
  parameter int CNT_W = 16,
  parameter int N_OUT = 32,
  parameter int DLY_W = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            tbl_we,
  input  logic [$clog2(N_EVT)-1:0]        tbl_addr,
  input  logic [CNT_W+$clog2(N_OUT):0]    tbl_wdata,
  input  logic                            cfg_split,
  input  logic                            cfg_tx,
  input  logic                            cfg_tmr_en,
  input  logic                            tmr_tick,
  input  logic                            sw_start,
  input  logic                            wd_trig,
  input  logic [DLY_W-1:0]                wd_dly,
  input  logic [N_OUT-1:0]                ovr_en,
  input  logic [N_OUT-1:0]                ovr_val,
  input  logic [2:0]                      irq_en,
  input  logic [2:0]                      irq_clr,
  output logic [N_OUT-1:0]                ctl_out,
  output logic [2:0]                      irq
);
  localparam int AW = $clog2(N_EVT);
  localparam int OW = $clog2(N_OUT);
  localparam int EW = CNT_W + OW + 1;
  localparam logic [AW-1:0] B1 = AW'(N_EVT / 4);
  localparam logic [AW-1:0] B2 = AW'(N_EVT / 2);
  localparam logic [AW-1:0] B3 = AW'(3 * (N_EVT / 4));
  localparam logic [AW-1:0] QL = AW'(N_EVT / 4 - 1);
  localparam logic [AW-1:0] HL = AW'(N_EVT / 2 - 1);

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_WU = 3'd1, S_ON = 3'd2, S_WDW = 3'd3, S_WD = 3'd4
  } st_t;

  st_t              st;
  logic [EW-1:0]    tbl [N_EVT];
  logic [AW-1:0]    ptr, base, last;
  logic [CNT_W-1:0] cnt;
  logic [DLY_W-1:0] dcnt;
  logic             tx_q, split_q;
  logic [N_OUT-1:0] seq_q;
  logic [2:0]       pend;

  wire start_req = sw_start | (cfg_tmr_en & tmr_tick);
  wire in_phase  = (st == S_WU) || (st == S_WD);
  wire is_wd     = (st == S_WD);

  always_comb begin
    if (split_q) begin
      last = QL;
      case ({tx_q, is_wd})
        2'b00:   base = '0;
        2'b01:   base = B1;
        2'b10:   base = B2;
        default: base = B3;
      endcase
    end else begin
      last = HL;
      base = is_wd ? B2 : '0;
    end
  end

  wire [EW-1:0]    ent   = tbl[base + ptr];
  wire [CNT_W-1:0] e_cnt = ent[EW-1 -: CNT_W];
  wire [OW-1:0]    e_idx = ent[OW:1];
  wire             e_set = ent[0];
  wire hit    = in_phase && (e_cnt == cnt);
  wire bad    = in_phase && (e_cnt < cnt);
  wire ph_end = hit && (ptr == last);

  wire wu_done = (st == S_WU) && ph_end;
  wire wd_done = is_wd && ph_end;
  wire err_set = ((st != S_IDLE) && start_req) || bad;

  always_ff @(posedge clk)
    if (tbl_we) tbl[tbl_addr] <= tbl_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ptr     <= '0;
      cnt     <= '0;
      dcnt    <= '0;
      tx_q    <= 1'b0;
      split_q <= 1'b0;
      seq_q   <= '0;
    end else begin
      case (st)
        S_IDLE: if (start_req) begin
          st      <= S_WU;
          cnt     <= '0;
          ptr     <= '0;
          tx_q    <= cfg_tx;
          split_q <= cfg_split;
        end
        S_WU, S_WD: begin
          if (bad) st <= S_IDLE;
          else if (hit) begin
            seq_q[e_idx] <= e_set;
            if (ph_end) st <= is_wd ? S_IDLE : S_ON;
            else        ptr <= ptr + AW'(1);
          end else cnt <= cnt + CNT_W'(1);
        end
        S_ON: if (wd_trig) begin
          if (wd_dly == '0) begin
            st  <= S_WD;
            cnt <= '0;
            ptr <= '0;
          end else begin
            st   <= S_WDW;
            dcnt <= DLY_W'(1);
          end
        end
        S_WDW: if (dcnt >= wd_dly) begin
          st  <= S_WD;
          cnt <= '0;
          ptr <= '0;
        end else dcnt <= dcnt + DLY_W'(1);
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~irq_clr) | {err_set, wd_done, wu_done};

  assign irq     = pend & irq_en;
  assign ctl_out = (ovr_en & ovr_val) | (~ovr_en & seq_q);
endmodule

// File: rtl/rf_evseq_chk.sv
module rf_evseq_chk #(
  parameter int N_OUT = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_start,
  input logic             tmr_tick,
  input logic             cfg_tmr_en,
  input logic             wd_trig,
  input logic [N_OUT-1:0] ovr_en,
  input logic [N_OUT-1:0] ovr_val,
  input logic [N_OUT-1:0] ctl_out,
  input logic [2:0]       irq,
  input logic [2:0]       irq_en,
  input logic [2:0]       st,
  input logic [2:0]       pend
);
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n) (irq & ~irq_en) == 3'b000); // R10
  AST_OVR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n) ((ctl_out ^ ovr_val) & ovr_en) == '0); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && !(sw_start || (cfg_tmr_en && tmr_tick))) |=> st == 3'd0); // R2
  AST_BUSY_START_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 3'd0 && sw_start) |=> pend[2]); // R8
  AST_WU_DONE_ON: assert property (@(posedge clk) disable iff (!rst_n) $rose(pend[0]) |-> st == 3'd2); // R5
  AST_WD_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) $rose(pend[1]) |-> st == 3'd0); // R7
  AST_WAIT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    st == 3'd3 |=> (st == 3'd3 || st == 3'd4)); // R6
  AST_ON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd2 && !wd_trig) |=> st == 3'd2); // R6
endmodule

bind rf_evseq rf_evseq_chk #(.N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .tmr_tick(tmr_tick),
  .cfg_tmr_en(cfg_tmr_en), .wd_trig(wd_trig), .ovr_en(ovr_en), .ovr_val(ovr_val),
  .ctl_out(ctl_out), .irq(irq), .irq_en(irq_en), .st(st), .pend(pend)
);

// File: tb/rf_evseq_tb_top.sv
`timescale 1ns/1ps
module rf_evseq_tb_top;
  logic clk = 0, rst_n = 0;
  logic tbl_we = 0;
  logic [4:0] tbl_addr = 0;
  logic [21:0] tbl_wdata = 0;
  logic cfg_split = 1, cfg_tx = 0, cfg_tmr_en = 0, tmr_tick = 0, sw_start = 0, wd_trig = 0;
  logic [15:0] wd_dly = 0;
  logic [31:0] ovr_en = 0, ovr_val = 0;
  logic [2:0] irq_en = 3'b111, irq_clr = 0;
  logic [31:0] ctl_out;
  logic [2:0] irq;

  rf_evseq dut_i (.*);

  always #2 clk = ~clk;

  int vectors = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  // behavioural reference model
  int m_tbl [32];
  int m_st = 0, m_cnt = 0, m_ptr = 0, m_dcnt = 0;
  bit m_tx = 0, m_split = 0;
  logic [31:0] m_seq = 0;
  logic [2:0]  m_pend = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_ptr = 0; m_dcnt = 0; m_seq = 0; m_pend = 0;
    end else begin
      bit sreq, wu, wd, er;
      int len, base, e, ec;
      sreq = sw_start | (cfg_tmr_en & tmr_tick);
      wu = 0; wd = 0; er = (m_st != 0) && sreq;
      case (m_st)
        0: if (sreq) begin m_st = 1; m_cnt = 0; m_ptr = 0; m_tx = cfg_tx; m_split = cfg_split; end
        1, 4: begin
          len  = m_split ? 8 : 16;
          base = m_split ? (int'(m_tx) * 2 + (m_st == 4 ? 1 : 0)) * 8 : (m_st == 4 ? 16 : 0);
          e  = m_tbl[base + m_ptr];
          ec = e >> 6;
          if (ec < m_cnt) begin er = 1; m_st = 0; end
          else if (ec == m_cnt) begin
            m_seq[(e >> 1) & 31] = e[0];
            if (m_ptr == len - 1) begin
              if (m_st == 1) begin m_st = 2; wu = 1; end
              else begin m_st = 0; wd = 1; end
            end else m_ptr++;
          end else m_cnt++;
        end
        2: if (wd_trig) begin
          if (wd_dly == 0) begin m_st = 4; m_cnt = 0; m_ptr = 0; end
          else begin m_st = 3; m_dcnt = 1; end
        end
        3: if (m_dcnt >= int'(wd_dly)) begin m_st = 4; m_cnt = 0; m_ptr = 0; end
           else m_dcnt++;
        default: ;
      endcase
      m_pend = (m_pend & ~irq_clr) | {er, wd, wu};
      if (tbl_we) m_tbl[tbl_addr] = int'(tbl_wdata);
    end
  end

  always @(negedge clk) begin
    logic [31:0] ex_ctl;
    logic [2:0]  ex_irq;
    ex_ctl = (ovr_en & ovr_val) | (~ovr_en & m_seq);
    ex_irq = m_pend & irq_en;
    vectors++;
    if (ctl_out !== ex_ctl || irq !== ex_irq) begin
      errors++;
      $display("FAIL %s cycle %0d: ctl_out=%h irq=%b expected ctl_out=%h irq=%b",
               cur_req, cycles, ctl_out, irq, ex_ctl, ex_irq);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d (R1..R11 run incomplete): got hang, expected finish", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int c, int idx, bit s);
    @(posedge clk); #1;
    tbl_we = 1; tbl_addr = 5'(a); tbl_wdata = {16'(c), 5'(idx), s};
    @(posedge clk); #1;
    tbl_we = 0;
  endtask

  task automatic start_sw();
    @(posedge clk); #1 sw_start = 1;
    @(posedge clk); #1 sw_start = 0;
  endtask

  task automatic clr_all();
    @(posedge clk); #1 irq_clr = 3'b111;
    @(posedge clk); #1 irq_clr = 3'b000;
  endtask

  // waits for irq[b]; returns the number of edges since the call
  task automatic wait_irq(int b, output int k);
    k = 0;
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      start_clear();
      k++;
      if (irq[b]) break;
    end
  endtask

  task automatic start_clear();
    sw_start = 0; tmr_tick = 0; wd_trig = 0;
  endtask

  initial begin
    int k;
    tick(3);
    chk("R1", ctl_out, 32'h0);
    chk("R1", {29'b0, irq}, 32'h0);
    rst_n = 1;
    tick(1);

    for (int i = 0; i < 8; i++) begin
      wr(i,      (i == 0) ? 2 : i + 1, i,     1);
      wr(8 + i,  20 + i,               i,     0);
      wr(16 + i, 1 + i,                8 + i, 1);
      wr(24 + i, 10 + i,               8 + i, 0);
    end

    cur_req = "R2";
    @(posedge clk); #1 tmr_tick = 1;
    @(posedge clk); #1 tmr_tick = 0;
    tick(30);
    chk("R2 timer ignored when disabled", ctl_out, 32'h0);
    chk("R2 timer ignored when disabled", {29'b0, irq}, 32'h0);

    cur_req = "R3";
    cfg_split = 1; cfg_tx = 0;
    @(posedge clk); #1 sw_start = 1;
    wait_irq(0, k);
    chk("R3 warm-up edge count", k, 17);
    chk("R5 receive warm-up outputs", ctl_out, 32'h0000_00FF);

    cur_req = "R8";
    start_sw();
    tick(1);
    chk("R8 busy start error", {29'b0, irq}, 32'h5);
    chk("R8 busy start ignored", ctl_out, 32'h0000_00FF);

    cur_req = "R10";
    irq_en = 3'b000; tick(2);
    chk("R10 masked", {29'b0, irq}, 32'h0);
    irq_en = 3'b111;
    clr_all(); tick(1);
    chk("R10 cleared", {29'b0, irq}, 32'h0);

    cur_req = "R6";
    wd_dly = 0;
    @(posedge clk); #1 wd_trig = 1;
    wait_irq(1, k);
    chk("R6 immediate warm-down edges", k, 36);
    chk("R7 receive warm-down outputs", ctl_out, 32'h0);
    tick(5);
    @(posedge clk); #1 wd_trig = 1;
    tick(5);
    wd_trig = 0;
    chk("R6 trigger ignored in idle", ctl_out, 32'h0);

    cur_req = "R4";
    clr_all();
    cfg_tx = 1; cfg_tmr_en = 1;
    @(posedge clk); #1 tmr_tick = 1;
    wait_irq(0, k);
    cfg_tx = 0;
    chk("R4 transmit region outputs", ctl_out, 32'h0000_FF00);
    cur_req = "R11";
    ovr_en = 32'h0000_0F0F; ovr_val = 32'h0000_0A05;
    tick(2);
    chk("R11 override", ctl_out, 32'h0000_FA05);
    cur_req = "R6";
    wd_dly = 5;
    @(posedge clk); #1 wd_trig = 1;
    wait_irq(1, k);
    chk("R6 delayed warm-down edges", k, 31);
    chk("R11 sequence ran under override", ctl_out, 32'h0000_0A05);
    ovr_en = 0; tick(1);
    chk("R7 transmit warm-down outputs", ctl_out, 32'h0);

    cur_req = "R4";
    clr_all();
    cfg_split = 0; cfg_tx = 1; wd_dly = 0;
    start_sw();
    wait_irq(0, k);
    chk("R4 combined warm-up", ctl_out, 32'h0);
    @(posedge clk); #1 wd_trig = 1;
    wait_irq(1, k);
    chk("R4 combined warm-down", ctl_out, 32'h0);

    cur_req = "R9";
    clr_all();
    cfg_split = 1; cfg_tx = 0;
    wr(3, 0, 3, 1);
    start_sw();
    wait_irq(2, k);
    tick(2);
    chk("R9 abort flag", {29'b0, irq}, 32'h4);
    chk("R9 outputs before bad entry", ctl_out, 32'h0000_0007);
    wr(3, 4, 3, 1);
    clr_all();
    start_sw();
    wait_irq(0, k);
    chk("R9 idle after abort, relaunch", ctl_out, 32'h0000_00FF);

    cur_req = "R10";
    @(posedge clk); #1 sw_start = 1; irq_clr = 3'b100;
    @(posedge clk); #1 sw_start = 0; irq_clr = 3'b000;
    tick(1);
    chk("R10 set wins over clear", {29'b0, irq}, 32'h5);

    tick(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule